// File: doc/BRIEF.md
# Paired-Instruction Accumulator Processor

This block is a small stored-program processor built around a single accumulator. It drives a synchronous memory of 40-bit words. Each word carries two 20-bit instructions. The processor reads a word once and executes the instruction in the upper half. It then executes the instruction in the lower half, and only after that moves the program counter to the next word. Programs and data share the same memory, so a program can store results next to its own code.

Data words are signed fixed-point values in sign-magnitude form: bit 39 is the sign and bits 38:0 are the magnitude. The block holds the program counter, a half-select bit, the accumulator, the multiplier-quotient register and a flag that records whether the last arithmetic result was positive. Loads, stores and adds address memory directly. A register-only add folds the multiplier-quotient register into the accumulator. Two jumps are provided: one unconditional and one taken only on a positive arithmetic result. A halt instruction stops all fetching.

The memory port has a fixed latency. Read data must appear on `mem_rdata` on the clock edge after the cycle in which `mem_rd_en` is high. The port has no valid/ready handshake and no back-pressure. The memory must always accept a request in the cycle it is issued.

Top module: `wpc_cpu`

## Requirements
- R1: A synchronous reset clears the program counter, half-select bit, accumulator, multiplier-quotient register and positive flag. In the first cycle after reset is released, the block reads word 0, whatever address it was executing before.
- R2: Each word is read exactly once. Its bits 39:20 execute first and its bits 19:0 second, and the program counter then advances by one to the next word.
- R3: Within each 20-bit half, bits 19:12 are the opcode and bits 11:0 are a direct word address.
- R4: LOAD (opcode 0x01) copies the addressed memory word into the accumulator and leaves the positive flag unchanged.
- R5: STORE (opcode 0x21) writes the accumulator to the addressed memory word.
- R6: ADD (opcode 0x05) replaces the accumulator with the sign-magnitude sum of the accumulator and the addressed word. With equal signs the magnitudes add modulo 2^39. With differing signs the smaller magnitude is taken from the larger, and the result takes the sign of the larger operand. A zero magnitude always gets sign 0.
- R7: ADDMQ (opcode 0x0F) adds the multiplier-quotient register into the accumulator by the rule of R6 and makes no memory access. Since nothing loads that register, it holds its reset value of zero.
- R8: JUMP (opcode 0x0D) loads the program counter from the address field from either half. Execution resumes with the upper half of the target word.
- R9: JPOS (opcode 0x10) jumps like JUMP only when the most recent ADD or ADDMQ result had sign 0 and a nonzero magnitude. Otherwise execution continues in sequence.
- R10: HALT (opcode 0x00) raises `halted`, which then stays high until reset, and no further memory access takes place.
- R11: Any other opcode is a no-operation: it makes no memory access and changes neither the accumulator nor the flag.
- R12: An operand read is issued in one cycle and its data is consumed from `mem_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd_en | output | 1 | Memory read request this cycle |
| mem_wr_en | output | 1 | Memory write request this cycle |
| mem_addr | output | 12 | Word address for the read or write |
| mem_wdata | output | 40 | Write data (the accumulator) |
| mem_rdata | input | 40 | Read data, valid one cycle after `mem_rd_en` |
| halted | output | 1 | High once a HALT has executed |

## Verification
The assertions assume that the memory honours the one-cycle read latency exactly and never stalls. They also assume that `rst` is held high from time zero until the first clock edges. The bench memory model registers read data on every edge where a read is requested and applies writes in the same edge. The stimulus therefore never breaks the latency rule. The bench loads programs only while reset is held, so no program change races with a fetch in flight.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_HALT  = 8'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 8'h01;
  localparam logic [OP_W-1:0] OP_ADD   = 8'h05;
  localparam logic [OP_W-1:0] OP_JUMP  = 8'h0D;
  localparam logic [OP_W-1:0] OP_ADDMQ = 8'h0F;
  localparam logic [OP_W-1:0] OP_JPOS  = 8'h10;
  localparam logic [OP_W-1:0] OP_STORE = 8'h21;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_OPND,
    ST_HALT
  } cpu_state_e;

endpackage

// File: rtl/wpc_sm_adder.sv
module wpc_sm_adder #(
  parameter int WORD_W = 40
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] sum_o
);
  localparam int MAG_W = WORD_W - 1;

  logic             a_sg, b_sg, r_sg;
  logic [MAG_W-1:0] a_mg, b_mg, r_mg;

  assign a_sg = a_i[WORD_W-1];
  assign b_sg = b_i[WORD_W-1];
  assign a_mg = a_i[MAG_W-1:0];
  assign b_mg = b_i[MAG_W-1:0];

  always_comb begin
    if (a_sg == b_sg) begin
      r_mg = a_mg + b_mg;
      r_sg = a_sg;
    end else if (a_mg >= b_mg) begin
      r_mg = a_mg - b_mg;
      r_sg = a_sg;
    end else begin
      r_mg = b_mg - a_mg;
      r_sg = b_sg;
    end
    if (r_mg == '0) r_sg = 1'b0;
  end

  assign sum_o = {r_sg, r_mg};

endmodule

// File: rtl/wpc_half_select.sv
module wpc_half_select #(
  parameter int WORD_W = 40,
  parameter int ADDR_W = 12
) (
  input  logic [WORD_W-1:0]      word_i,
  input  logic                   low_half_i,
  output logic [wpc_pkg::OP_W-1:0] op_o,
  output logic [ADDR_W-1:0]      field_o
);
  localparam int INSN_W = WORD_W / 2;

  logic [INSN_W-1:0] hi_insn, lo_insn, pick;

  assign hi_insn = word_i[WORD_W-1 -: INSN_W];
  assign lo_insn = word_i[INSN_W-1:0];
  assign pick    = low_half_i ? lo_insn : hi_insn;
  assign op_o    = pick[INSN_W-1 -: wpc_pkg::OP_W];
  assign field_o = pick[ADDR_W-1:0];

endmodule

// File: rtl/wpc_cpu.sv
module wpc_cpu #(
  parameter int WORD_W = 40,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted
);
  import wpc_pkg::*;

  localparam int MAG_W = WORD_W - 1;

  cpu_state_e        state;
  logic [ADDR_W-1:0] pc;
  logic              half_q;
  logic [WORD_W-1:0] ir, ac, mq;
  logic              pos_q;

  logic [OP_W-1:0]   cur_op;
  logic [ADDR_W-1:0] cur_fld;
  logic [WORD_W-1:0] add_b, sum;
  logic              sum_pos, arith_now;

  logic [ADDR_W-1:0] adv_pc;
  logic              adv_half;
  cpu_state_e        adv_state;

  wpc_half_select #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_sel (
    .word_i     (ir),
    .low_half_i (half_q),
    .op_o       (cur_op),
    .field_o    (cur_fld)
  );

  assign add_b = (state == ST_OPND) ? mem_rdata : mq;

  wpc_sm_adder #(.WORD_W(WORD_W)) u_add (
    .a_i   (ac),
    .b_i   (add_b),
    .sum_o (sum)
  );

  assign sum_pos   = !sum[WORD_W-1] && (sum[MAG_W-1:0] != '0);
  assign arith_now = ((state == ST_OPND) && (cur_op == OP_ADD)) ||
                     ((state == ST_EXEC) && (cur_op == OP_ADDMQ));
  assign halted    = (state == ST_HALT);

  // Sequencing after a half completes without a jump.
  always_comb begin
    if (!half_q) begin
      adv_half  = 1'b1;
      adv_pc    = pc;
      adv_state = ST_EXEC;
    end else begin
      adv_half  = 1'b0;
      adv_pc    = pc + ADDR_W'(1);
      adv_state = ST_FETCH;
    end
  end

  // Memory port requests.
  always_comb begin
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_addr  = pc;
    mem_wdata = ac;
    if (state == ST_FETCH) begin
      mem_rd_en = 1'b1;
    end else if (state == ST_EXEC) begin
      if ((cur_op == OP_LOAD) || (cur_op == OP_ADD)) begin
        mem_rd_en = 1'b1;
        mem_addr  = cur_fld;
      end else if (cur_op == OP_STORE) begin
        mem_wr_en = 1'b1;
        mem_addr  = cur_fld;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      pc     <= '0;
      half_q <= 1'b0;
      ir     <= '0;
      ac     <= '0;
      mq     <= '0;
      pos_q  <= 1'b0;
    end else begin
      mq <= mq;
      case (state)
        ST_FETCH:  state <= ST_DECODE;
        ST_DECODE: begin
          ir    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          case (cur_op)
            OP_HALT: state <= ST_HALT;
            OP_LOAD, OP_ADD: state <= ST_OPND;
            OP_JUMP: begin
              pc     <= cur_fld;
              half_q <= 1'b0;
              state  <= ST_FETCH;
            end
            OP_JPOS: begin
              if (pos_q) begin
                pc     <= cur_fld;
                half_q <= 1'b0;
                state  <= ST_FETCH;
              end else begin
                pc     <= adv_pc;
                half_q <= adv_half;
                state  <= adv_state;
              end
            end
            default: begin
              if (cur_op == OP_ADDMQ) begin
                ac    <= sum;
                pos_q <= sum_pos;
              end
              pc     <= adv_pc;
              half_q <= adv_half;
              state  <= adv_state;
            end
          endcase
        end
        ST_OPND: begin
          if (cur_op == OP_LOAD) begin
            ac <= mem_rdata;
          end else begin
            ac    <= sum;
            pos_q <= sum_pos;
          end
          pc     <= adv_pc;
          half_q <= adv_half;
          state  <= adv_state;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  AST_PC_STEADY_MID_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(half_q) |-> $stable(pc)); // R2

  AST_FETCH_FROM_UPPER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> !half_q); // R8

  AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(arith_now) |-> !(ac[WORD_W-1] && (ac[MAG_W-1:0] == '0))); // R6

  AST_FLAG_TRACKS_SUM: assert property (@(posedge clk) disable iff (rst)
    $past(arith_now) |-> (pos_q == (!ac[WORD_W-1] && (ac[MAG_W-1:0] != '0)))); // R9

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R10

  AST_OPND_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPND) |-> $past(mem_rd_en)); // R12

endmodule

// File: tb/wpc_cpu_tb.sv
module wpc_cpu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int WW = 40;
  localparam logic [WW-1:0] SENT = 40'h5A_5A5A_5A5A;

  localparam logic [7:0] C_HALT = 8'h00, C_LOAD = 8'h01, C_ADD = 8'h05,
                         C_JUMP = 8'h0D, C_ADDMQ = 8'h0F, C_JPOS = 8'h10,
                         C_STORE = 8'h21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_rd_en, mem_wr_en, halted;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic [WW-1:0] mem_rdata = '0;

  logic [WW-1:0] mem [0:(1<<AW)-1];

  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int fetch_n = 0;
  int fetch_log [0:15];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpc_cpu #(.WORD_W(WW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_rd_en) begin
        rd_cnt++;
        if (mem_addr < 64 && fetch_n < 16) begin
          fetch_log[fetch_n] = int'(mem_addr);
          fetch_n++;
        end
      end
      if (mem_wr_en) wr_cnt++;
    end
  end

  function automatic logic [19:0] ins(input logic [7:0] op, input int a);
    return {op, 12'(a)};
  endfunction

  function automatic logic [WW-1:0] sm_add(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [WW-2:0] m;
    logic s;
    if (a[WW-1] == b[WW-1]) begin m = a[WW-2:0] + b[WW-2:0]; s = a[WW-1]; end
    else if (a[WW-2:0] >= b[WW-2:0]) begin m = a[WW-2:0] - b[WW-2:0]; s = a[WW-1]; end
    else begin m = b[WW-2:0] - a[WW-2:0]; s = b[WW-1]; end
    if (m == '0) s = 1'b0;
    return {s, m};
  endfunction

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    for (int i = 100; i < 120; i++) mem[i] = SENT;
  endtask

  task automatic put(input int a, input logic [19:0] hi, input logic [19:0] lo);
    mem[a] = {hi, lo};
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    fetch_n = 0;
    rst = 1'b0;
  endtask

  task automatic run_prog(input string req);
    bit done;
    do_reset();
    done = 0;
    for (int c = 0; c < 2000 && !done; c++) begin
      @(negedge clk);
      if (halted) done = 1;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL %s actual=no-halt expected=halt", req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] va, vb, vs, vx, vy;
    int rd0, wr0;

    // R1: reset state and first fetch
    clear_mem();
    put(0, ins(C_STORE, 100), ins(C_HALT, 0));
    do_reset();
    #1;
    chk("R1 halted low after reset", WW'(halted), WW'(0));
    chk("R1 first read enable", WW'(mem_rd_en), WW'(1));
    chk("R1 first address is 0", WW'(mem_addr), WW'(0));
    run_prog("R1 run");
    chk("R1 accumulator cleared", mem[100], '0);
    chk("R10 halted raised", WW'(halted), WW'(1));

    // R2 R3 R4 R5: half order and load/store
    clear_mem();
    mem[100] = 40'h00_1234_5678;
    mem[101] = 40'h80_0000_0042;
    put(0, ins(C_LOAD, 100), ins(C_STORE, 110));
    put(1, ins(C_LOAD, 101), ins(C_STORE, 111));
    put(2, ins(C_HALT, 0), ins(C_STORE, 112));
    run_prog("R2 run");
    chk("R4 load/store first word", mem[110], 40'h00_1234_5678);
    chk("R5 load/store second word", mem[111], 40'h80_0000_0042);
    chk("R3 upper-half halt stops word", mem[112], SENT);
    chk("R2 fetch count", WW'(fetch_n), WW'(3));
    chk("R2 fetch order 0", WW'(fetch_log[0]), WW'(0));
    chk("R2 fetch order 1", WW'(fetch_log[1]), WW'(1));
    chk("R2 fetch order 2", WW'(fetch_log[2]), WW'(2));

    // R7: ADDMQ normalises negative zero, no memory access, flag stays non-positive
    clear_mem();
    mem[100] = {1'b1, 39'd0};
    put(0, ins(C_LOAD, 100), ins(C_ADDMQ, 100));
    put(1, ins(C_STORE, 110), ins(C_JPOS, 3));
    put(2, ins(C_STORE, 111), ins(C_HALT, 0));
    put(3, ins(C_STORE, 112), ins(C_HALT, 0));
    run_prog("R7 run");
    chk("R7 negative zero becomes +0", mem[110], '0);
    chk("R9 zero result not taken", mem[111], '0);
    chk("R9 zero result target untouched", mem[112], SENT);
    chk("R7 read count", WW'(rd_cnt), WW'(4));
    chk("R7 write count", WW'(wr_cnt), WW'(2));

    // R8: jumps from both halves resume at upper half
    clear_mem();
    mem[100] = 40'h00_0000_0777;
    put(0, ins(C_LOAD, 100), ins(C_JUMP, 4));
    put(1, ins(C_STORE, 110), ins(C_HALT, 0));
    put(4, ins(C_JUMP, 6), ins(C_STORE, 111));
    put(6, ins(C_STORE, 112), ins(C_HALT, 0));
    run_prog("R8 run");
    chk("R8 skipped word untouched", mem[110], SENT);
    chk("R8 lower half after jump skipped", mem[111], SENT);
    chk("R8 target reached", mem[112], 40'h00_0000_0777);
    chk("R8 fetch path 4", WW'(fetch_log[1]), WW'(4));
    chk("R8 fetch path 6", WW'(fetch_log[2]), WW'(6));

    // R9: LOAD does not disturb the positive flag
    clear_mem();
    mem[100] = 40'd5;
    mem[101] = 40'd3;
    mem[102] = {1'b1, 39'd7};
    put(0, ins(C_LOAD, 100), ins(C_ADD, 101));
    put(1, ins(C_LOAD, 102), ins(C_JPOS, 3));
    put(2, ins(C_STORE, 110), ins(C_HALT, 0));
    put(3, ins(C_STORE, 111), ins(C_HALT, 0));
    run_prog("R9 run");
    chk("R9 flag kept across load, not-taken path", mem[110], SENT);
    chk("R9 flag kept across load, taken path", mem[111], {1'b1, 39'd7});

    // R11 R10: unknown opcodes are no-ops; halt silences the port
    clear_mem();
    mem[100] = 40'h12_3456_789A;
    put(0, ins(C_LOAD, 100), ins(8'h33, 110));
    put(1, ins(8'hFF, 111), ins(C_STORE, 112));
    put(2, ins(C_HALT, 0), ins(C_HALT, 0));
    run_prog("R11 run");
    chk("R11 no-op address untouched A", mem[110], SENT);
    chk("R11 no-op address untouched B", mem[111], SENT);
    chk("R11 accumulator kept", mem[112], 40'h12_3456_789A);
    chk("R11 read count", WW'(rd_cnt), WW'(4));
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    repeat (20) @(negedge clk);
    chk("R10 no reads after halt", WW'(rd_cnt), WW'(rd0));
    chk("R10 no writes after halt", WW'(wr_cnt), WW'(wr0));
    chk("R10 halted stays high", WW'(halted), WW'(1));

    // R6: magnitude wrap to zero gives +0
    clear_mem();
    mem[100] = {1'b0, {39{1'b1}}};
    mem[101] = 40'd1;
    put(0, ins(C_LOAD, 100), ins(C_ADD, 101));
    put(1, ins(C_STORE, 110), ins(C_HALT, 0));
    run_prog("R6 wrap run");
    chk("R6 wrap modulo 2^39", mem[110], '0);

    // R1: reset during a running loop returns to word 0
    clear_mem();
    put(0, ins(C_JUMP, 5), ins(C_HALT, 0));
    put(5, ins(8'h33, 0), ins(C_JUMP, 5));
    do_reset();
    repeat (30) @(negedge clk);
    chk("R1 loop reached word 5", WW'(fetch_log[1]), WW'(5));
    do_reset();
    #1;
    chk("R1 restart reads", WW'(mem_rd_en), WW'(1));
    chk("R1 restart address 0", WW'(mem_addr), WW'(0));

    // R6 R9 R4 R5: random sign-magnitude sums and branch decisions
    void'($urandom(32'd20240601));
    for (int it = 0; it < 40; it++) begin
      va = {$urandom, $urandom};
      vb = {$urandom, $urandom};
      if ((it % 4) == 1) vb[WW-2:0] = va[WW-2:0];
      if ((it % 5) == 2) vb[WW-2:0] = 39'($urandom % 16);
      vx = {$urandom, $urandom};
      vy = {$urandom, $urandom};
      vs = sm_add(va, vb);
      clear_mem();
      mem[100] = va;
      mem[101] = vb;
      mem[103] = vx;
      mem[105] = vy;
      put(0, ins(C_LOAD, 100), ins(C_ADD, 101));
      put(1, ins(C_STORE, 102), ins(C_JPOS, 4));
      put(2, ins(C_LOAD, 103), ins(C_STORE, 104));
      put(3, ins(C_HALT, 0), ins(C_HALT, 0));
      put(4, ins(C_LOAD, 105), ins(C_STORE, 104));
      put(5, ins(C_HALT, 0), ins(C_HALT, 0));
      run_prog("R6 random run");
      chk("R6 random sum", mem[102], vs);
      chk("R9 random branch", mem[104],
          (!vs[WW-1] && vs[WW-2:0] != '0) ? vy : vx);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule